// File: doc/BRIEF.md
# Burst-Mode Oversampled Phase Aligner

This block takes serial data from upstream bursts whose phase against the local clock is unknown. The serial input is sampled on every edge of a clock running at eight times the bit rate. A bit-rate enable marks one edge in every eight, and that edge is phase 0 of each bit period. Every burst is announced by a rising edge on the burst reset input. That input is brought into the clock domain through a two-flop synchroniser and then edge-detected. The block then waits a short settling interval and listens to an alternating preamble. Over that window it builds a histogram of where the data transitions fall among the eight phases.

The phase with the most transitions is taken as the data edge. The block then samples each bit half a bit period away from it. That choice is frozen for the rest of the burst. The retimed bits leave on a single output, gated by a lock flag that rises at a fixed latency after the reset edge. If the preamble window shows no transitions at all, the block never locks and keeps its output low until the next burst reset.

Top module: `burst_phase_aligner`

## Requirements
- R1: If burst_rst is first sampled high at clock edge r after having been low, lock is 0 after edge r+2 and stays 0 until reacquisition. After edge r+1, lock still holds its earlier value. This applies in the middle of a locked burst as well.
- R2: The phase of a clock edge is 0 when bit_en is high at that edge, and it rises by one on each following edge. Lock rises exactly at the edge that carries the 17th bit_en pulse after edge r+2, never earlier. Those 17 bit periods are 5 of initialisation, 8 of measurement and 4 of output fill.
- R3: A transition is an edge whose sdin sample differs from the sample at the previous edge. Transitions are counted per phase over the 64 edges that follow the 5th bit_en edge after r+2. The edge phase is the phase with the highest count, and a tie goes to the lowest phase number. The sampling phase is the edge phase plus 4, modulo 8.
- R4: While lock is 1, data_out after any edge equals the sdin sample taken at the most recent edge whose phase equals the sampling phase.
- R5: Whenever lock is 0, data_out is 0.
- R6: If no transition is counted in the measurement window, lock stays 0 and data_out stays 0 until the next burst reset.
- R7: Once measured, the sampling phase stays fixed until the next burst reset, even if the input edges move later in the burst.
- R8: A burst reset during a locked burst restarts acquisition. The new sampling phase depends only on the new preamble.
- R9: While rst_n is low, and afterwards until the first burst reset, lock and data_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, eight edges per bit period |
| rst_n | input | 1 | Active-low chip reset |
| bit_en | input | 1 | One-cycle pulse once per bit period, marks phase 0 |
| burst_rst | input | 1 | Asynchronous burst start, rising edge is active |
| sdin | input | 1 | Serial data, sampled on every clock edge |
| data_out | output | 1 | Retimed bit-rate data, 0 while unlocked |
| lock | output | 1 | High while the retimed data is valid |

## Verification
Several behaviours are checked on every cycle by the assertions: lock falls after a synchronised reset pulse, lock rises only on a bit-rate edge and after the exact count of bit periods, a lock never follows an empty histogram, data stays quiet while unlocked, and the sampling phase is stable while locked. Other behaviours can only be shown by the bench's scenarios. These are whether the chosen phase is the right one, including the lowest-index tie-break under pulse-width distortion, whether the retimed bits equal the samples at that phase, and whether a mid-burst reset leads to a fresh phase choice. The bench reaches them by rebuilding the histogram from its own stimulus and comparing every retimed bit.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

  localparam int unsigned OSR_DEF       = 8;
  localparam int unsigned INIT_BITS_DEF = 5;
  localparam int unsigned MEAS_BITS_DEF = 8;
  localparam int unsigned FILL_BITS_DEF = 4;
  localparam int unsigned SYNC_DEF      = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_MEAS,
    ST_FILL,
    ST_RUN,
    ST_DEAD
  } bpa_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bpa_rst_sync.sv
module bpa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_rst,
  output logic rst_pulse
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], burst_rst};
  end

  // rising edge seen after the synchroniser stages
  assign rst_pulse = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/bpa_phase_meas.sv
module bpa_phase_meas #(
  parameter int unsigned OSR       = 8,
  parameter int unsigned MEAS_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic                     sdin,
  input  logic                     clear,
  input  logic                     meas_en,
  output logic [$clog2(OSR)-1:0]   cur_ph,
  output logic [$clog2(OSR)-1:0]   samp_ph,
  output logic                     any_edge
);

  localparam int unsigned PH_W  = $clog2(OSR);
  localparam int unsigned CNT_W = $clog2(MEAS_BITS + 1);
  localparam logic [PH_W-1:0] HALF = PH_W'(OSR / 2);

  typedef logic [CNT_W-1:0] hist_t [OSR];

  logic [PH_W-1:0] ph_q;
  logic            sd_d;
  logic            trans;
  hist_t           hits;
  logic [PH_W-1:0] edge_ph;

  // highest count wins, the lowest phase index wins a tie
  function automatic logic [PH_W-1:0] busiest(input hist_t h);
    logic [PH_W-1:0] best;
    logic [CNT_W-1:0] top;
    best = '0;
    top  = h[0];
    for (int p = 1; p < OSR; p++) begin
      if (h[p] > top) begin
        top  = h[p];
        best = PH_W'(p);
      end
    end
    return best;
  endfunction

  // sample half a bit away from the edge (OSR is a power of two)
  function automatic logic [PH_W-1:0] opposite(input logic [PH_W-1:0] e);
    return e + HALF;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      sd_d <= 1'b0;
    end else begin
      ph_q <= bit_en ? PH_W'(1) : ph_q + PH_W'(1);
      sd_d <= sdin;
    end
  end

  assign cur_ph = bit_en ? '0 : ph_q;
  assign trans  = sdin ^ sd_d;

  for (genvar p = 0; p < OSR; p++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hits[p] <= '0;
      else if (clear)
        hits[p] <= '0;
      else if (meas_en && trans && (cur_ph == PH_W'(p)))
        hits[p] <= hits[p] + CNT_W'(1);
    end
  end

  always_comb begin
    any_edge = 1'b0;
    for (int p = 0; p < OSR; p++) any_edge = any_edge | (|hits[p]);
  end

  assign edge_ph = busiest(hits);
  assign samp_ph = opposite(edge_ph);

endmodule

// File: rtl/bpa_seq.sv
module bpa_seq
  import bpa_pkg::*;
#(
  parameter int unsigned INIT_BITS = INIT_BITS_DEF,
  parameter int unsigned MEAS_BITS = MEAS_BITS_DEF,
  parameter int unsigned FILL_BITS = FILL_BITS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_en,
  input  logic any_edge,
  output logic meas_en,
  output logic capture_en,
  output logic lock
);

  localparam int unsigned LONGEST = max3(INIT_BITS, MEAS_BITS, FILL_BITS);
  localparam int unsigned BC_W    = $clog2(LONGEST + 1);

  bpa_state_t      state;
  logic [BC_W-1:0] bcnt;
  logic            last_bit;

  function automatic logic [BC_W-1:0] final_count(input bpa_state_t s);
    case (s)
      ST_INIT: return BC_W'(INIT_BITS - 1);
      ST_MEAS: return BC_W'(MEAS_BITS - 1);
      default: return BC_W'(FILL_BITS - 1);
    endcase
  endfunction

  assign last_bit = (bcnt == final_count(state));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      bcnt  <= '0;
    end else if (start) begin
      state <= ST_INIT;
      bcnt  <= '0;
    end else if (bit_en) begin
      case (state)
        ST_INIT: begin
          if (last_bit) begin state <= ST_MEAS; bcnt <= '0; end
          else bcnt <= bcnt + BC_W'(1);
        end
        ST_MEAS: begin
          if (last_bit) begin state <= ST_FILL; bcnt <= '0; end
          else bcnt <= bcnt + BC_W'(1);
        end
        ST_FILL: begin
          if (last_bit) begin
            state <= any_edge ? ST_RUN : ST_DEAD;
            bcnt  <= '0;
          end else bcnt <= bcnt + BC_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign meas_en    = (state == ST_MEAS);
  assign capture_en = (state == ST_FILL) || (state == ST_RUN);
  assign lock       = (state == ST_RUN);

endmodule

// File: rtl/bpa_retimer.sv
module bpa_retimer #(
  parameter int unsigned OSR = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   capture_en,
  input  logic                   lock,
  input  logic                   sdin,
  input  logic [$clog2(OSR)-1:0] cur_ph,
  input  logic [$clog2(OSR)-1:0] samp_ph,
  output logic                   data_out
);

  logic data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= 1'b0;
    else if (start)
      data_q <= 1'b0;
    else if (capture_en && (cur_ph == samp_ph))
      data_q <= sdin;
  end

  assign data_out = lock & data_q;

endmodule

// File: rtl/burst_phase_aligner.sv
module burst_phase_aligner
  import bpa_pkg::*;
#(
  parameter int unsigned OSR         = OSR_DEF,
  parameter int unsigned INIT_BITS   = INIT_BITS_DEF,
  parameter int unsigned MEAS_BITS   = MEAS_BITS_DEF,
  parameter int unsigned FILL_BITS   = FILL_BITS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic burst_rst,
  input  logic sdin,
  output logic data_out,
  output logic lock
);

  localparam int unsigned PH_W = $clog2(OSR);

  logic            rst_pulse;
  logic            meas_en;
  logic            capture_en;
  logic            any_edge;
  logic [PH_W-1:0] cur_ph;
  logic [PH_W-1:0] samp_ph;

  bpa_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .burst_rst (burst_rst),
    .rst_pulse (rst_pulse)
  );

  bpa_phase_meas #(.OSR(OSR), .MEAS_BITS(MEAS_BITS)) u_meas (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sdin     (sdin),
    .clear    (rst_pulse),
    .meas_en  (meas_en),
    .cur_ph   (cur_ph),
    .samp_ph  (samp_ph),
    .any_edge (any_edge)
  );

  bpa_seq #(.INIT_BITS(INIT_BITS), .MEAS_BITS(MEAS_BITS), .FILL_BITS(FILL_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rst_pulse),
    .bit_en     (bit_en),
    .any_edge   (any_edge),
    .meas_en    (meas_en),
    .capture_en (capture_en),
    .lock       (lock)
  );

  bpa_retimer #(.OSR(OSR)) u_retime (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rst_pulse),
    .capture_en (capture_en),
    .lock       (lock),
    .sdin       (sdin),
    .cur_ph     (cur_ph),
    .samp_ph    (samp_ph),
    .data_out   (data_out)
  );

endmodule

// File: rtl/bpa_chk.sv
module bpa_chk #(
  parameter int unsigned OSR        = 8,
  parameter int unsigned TOTAL_BITS = 17
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bit_en,
  input logic                   rst_pulse,
  input logic                   lock,
  input logic                   data_out,
  input logic                   any_edge,
  input logic [$clog2(OSR)-1:0] samp_ph
);

  logic [5:0] en_cnt;

  // bit periods seen since the last synchronised reset pulse (saturating)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      en_cnt <= '0;
    else if (rst_pulse)              en_cnt <= '0;
    else if (bit_en && en_cnt != '1) en_cnt <= en_cnt + 6'd1;
  end

  assert_lock_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !lock);

  assert_lock_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (en_cnt == 6'(TOTAL_BITS)));

  assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(bit_en));

  assert_quiet_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> !data_out);

  assert_no_lock_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> any_edge);

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(samp_ph));

endmodule

bind burst_phase_aligner bpa_chk #(
  .OSR        (OSR),
  .TOTAL_BITS (INIT_BITS + MEAS_BITS + FILL_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .rst_pulse (rst_pulse),
  .lock      (lock),
  .data_out  (data_out),
  .any_edge  (any_edge),
  .samp_ph   (samp_ph)
);

// File: tb/test_burst_phase_aligner.sv
`timescale 1ns/1ps
module test_burst_phase_aligner;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic burst_rst = 1'b0;
  logic sdin = 1'b0;
  logic data_out;
  logic lock;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int n = 0;
  int rst_lo = -100, rst_hi = -100;
  int mode = 0, e_off = 0, seed = 0, kpre = 0, da = 0, db = 0;

  always #2.5 clk = ~clk;

  burst_phase_aligner i_burst_phase_aligner (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .burst_rst(burst_rst),
    .sdin(sdin), .data_out(data_out), .lock(lock)
  );

  typedef struct packed {
    logic [1:0] md;   // 0 clean preamble+payload, 1 flat line, 2 distorted duty
    logic [2:0] a;    // edge offset, or rise phase when distorted
    logic [7:0] b;    // payload seed, or fall phase when distorted
    logic       sh;   // move the input edges after lock
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 3'd0, 8'h11, 1'b0},
    '{2'd0, 3'd3, 8'h5a, 1'b0},
    '{2'd2, 3'd2, 8'd6,  1'b0},
    '{2'd1, 3'd0, 8'h00, 1'b0},
    '{2'd0, 3'd5, 8'hc3, 1'b1},
    '{2'd0, 3'd7, 8'h2e, 1'b0}
  };

  function automatic bit gen(input int c);
    int k, v, j;
    if (mode == 1) return 1'b0;
    if (mode == 2) begin
      j = c % 16;
      return (j >= da) && (j < 8 + db);
    end
    k = (c + 64 - e_off) / 8;
    if (k < kpre) return k[0];
    v = k * 37 + seed;
    return v[3] ^ v[1];
  endfunction

  // rebuild the per-phase transition histogram from the stimulus
  task automatic ref_pick(input int b1, output int sel, output bit anye);
    int hist [8];
    int best;
    for (int p = 0; p < 8; p++) hist[p] = 0;
    for (int m = b1 + 33; m <= b1 + 96; m++)
      if (gen(m) != gen(m - 1)) hist[m % 8]++;
    best = 0;
    anye = 1'b0;
    for (int p = 0; p < 8; p++) if (hist[p] != 0) anye = 1'b1;
    for (int p = 1; p < 8; p++) if (hist[p] > hist[best]) best = p;
    sel = (best + 4) % 8;
  endtask

  task automatic tick();
    @(negedge clk);
    n = n + 1;
    bit_en    = (n % 8 == 0);
    burst_rst = (n >= rst_lo) && (n <= rst_hi);
    sdin      = gen(n);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, n - 1);
    end
  endtask

  task automatic do_burst(input bit was_locked, input bit shift_en, input int tail_bits,
                          input string dtag);
    int r, b1, lk, sel, obs, m, stop;
    bit anye, quiet_ok;
    string tag;
    r = n + 1;
    rst_lo = r; rst_hi = r + 2;
    kpre = (r + 140 + 64 - e_off) / 8;
    b1 = ((r + 2) / 8 + 1) * 8;
    lk = b1 + 128;
    ref_pick(b1, sel, anye);
    stop = lk + 8 * tail_bits;
    quiet_ok = 1'b1;
    tag = dtag;
    obs = n;
    while (obs < stop) begin
      tick();
      obs = n - 1;
      if (obs == r + 1 && was_locked) chk(lock == 1'b1, "R1 lock held one edge", lock, 1);
      if (obs == r + 2) chk(lock == 1'b0, "R1 lock cleared", lock, 0);
      if (obs >= r + 2 && (!anye || obs < lk))
        if (lock || data_out) quiet_ok = 1'b0;
      if (anye && obs == lk - 1) chk(lock == 1'b0, "R2 lock not early", lock, 0);
      if (anye && obs == lk) chk(lock == 1'b1, "R2 lock latency", lock, 1);
      if (anye && obs >= lk && (obs % 8 == sel || obs == lk)) begin
        m = obs - ((obs - sel + 8) % 8);
        chk(data_out == gen(m), {tag, " retimed bit (R3 phase)"}, data_out, gen(m));
      end
      if (shift_en && obs == lk + 16) begin
        e_off = (e_off + 4) % 8;
        tag = "R7";
      end
    end
    if (anye) chk(quiet_ok, "R5 quiet before lock", quiet_ok, 1);
    else      chk(quiet_ok, "R6 no lock without edges", quiet_ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit idle_ok;
    // R9: chip reset state
    repeat (4) tick();
    chk(lock == 1'b0, "R9 lock in reset", lock, 0);
    chk(data_out == 1'b0, "R9 data in reset", data_out, 0);
    rst_n = 1'b1;
    idle_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      tick();
      if (lock || data_out) idle_ok = 1'b0;
    end
    chk(idle_ok, "R9 idle without burst reset", idle_ok, 1);

    // table-driven bursts (R2..R7)
    for (int i = 0; i < 6; i++) begin
      mode  = int'(VECS[i].md);
      e_off = int'(VECS[i].a);
      seed  = int'(VECS[i].b);
      da    = int'(VECS[i].a);
      db    = int'(VECS[i].b);
      do_burst(1'b0, VECS[i].sh, 14, "R4");
      repeat (5) tick();
    end

    // R8: reset in the middle of a locked burst, new phase from new preamble
    mode = 0; e_off = 3; seed = 8'h77;
    do_burst(1'b0, 1'b0, 3, "R4");
    e_off = 6; seed = 8'h19;
    do_burst(1'b1, 1'b0, 12, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule